// File: doc/BRIEF.md
# Dual-processor IPC mailbox FIFO

This block lets two processors, called side A and side B, pass 32-bit words and a small handshake nibble to each other. Each side reaches its own bank of four registers through a plain register bus: a read strobe, a write strobe, a two-bit register select, byte enables, write data and read data. The four registers are a sync register, a FIFO control register, a write-only send port and a read-only receive port. Each side owns a send FIFO, and the other side drains it through its receive port.

The two banks are cross-coupled. The sync register of each side shows, in its low nibble, the output nibble that the peer last wrote. The empty and full flags of a FIFO appear twice: as send status in the owner's control register and as receive status in the peer's control register. Reading an empty FIFO returns the last word read from it and raises a sticky error flag. Pushing into a full FIFO is dropped and also raises the error flag. The bus has no back-pressure. Every access completes in the cycle it is presented. Read data is combinational from the current state, and every state change lands on the next rising clock edge.

Register select codes: 0 is sync, 1 is control, 2 is the send port, and 3 is the receive port. Byte lane k of a write covers bits 8k+7 to 8k.

Top module: `ipc_mailbox`

## Requirements
- R1: After reset, both sync registers read 0x0000_0000. Both control registers read 0x0000_0101, meaning send-empty (bit 0) and receive-empty (bit 8).
- R2: A sync write changes only bits 8–11 (the output nibble) and bits 13–14. Bits 0–3 read back the peer's bits 8–11. All other bits read 0.
- R3: A control write changes only bit 2, bit 10 and bit 15 (the FIFO enable). Bits 0, 1, 8 and 9 are status: send-empty, send-full, receive-empty and receive-full. Bit 3 always reads 0.
- R4: A send-port write is ignored while the writer's enable bit 15 is clear. Neither side's flags change.
- R5: Each send FIFO holds 16 words and delivers them in order. Full is set at occupancy 16 and empty at occupancy 0. Every push or pop updates the owner's send flags and the peer's receive flags in the same cycle.
- R6: A receive-port read with the reader's enable bit clear returns the head word and does not remove it.
- R7: A receive-port read of an empty FIFO sets the reader's error bit 14. It returns the last word read from that FIFO, or 0 if no word has ever been read.
- R8: Error bit 14 is sticky. Writing 1 to it clears it. Writing 0 to it leaves it unchanged.
- R9: A push into a full FIFO is dropped. The stored words are kept, and the writer's error bit is set.
- R10: Writing 1 to control bit 3 empties the writer's send FIFO in that cycle. This sets the writer's send-empty flag and the peer's receive-empty flag.
- R11: A push and a pop of the same FIFO in one cycle both take effect, even when the FIFO is full. The occupancy is unchanged, and no error is raised.
- R12: In a sync or control write, a byte lane whose byte enable is clear keeps its old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| a_rd | input | 1 | Side A read strobe |
| a_wr | input | 1 | Side A write strobe |
| a_sel | input | 2 | Side A register select |
| a_be | input | 4 | Side A byte enables |
| a_wdata | input | 32 | Side A write data |
| a_rdata | output | 32 | Side A read data (combinational) |
| b_rd | input | 1 | Side B read strobe |
| b_wr | input | 1 | Side B write strobe |
| b_sel | input | 2 | Side B register select |
| b_be | input | 4 | Side B byte enables |
| b_wdata | input | 32 | Side B write data |
| b_rdata | output | 32 | Side B read data (combinational) |

## Verification
The assertions check the following on every cycle:
- The occupancy never exceeds the depth.
- A dropped push, or a read with the enable bit clear, leaves the occupancy as it was.
- A flush always leaves the FIFO empty.
- A simultaneous push and pop keeps the count.
- The error flag holds until it is cleared.

Only the bench scenarios can show the rest: word order through a full FIFO, the values returned on repeated and empty reads, the cross-coupled sync nibble and status flags seen from both sides, and the byte-lane masking of register writes.

// File: rtl/ipc_pkg.sv
package ipc_pkg;
  localparam int REG_W = 32;
  localparam int NIB_W = 4;

  typedef enum logic [1:0] {
    SEL_SYNC = 2'd0,
    SEL_CTRL = 2'd1,
    SEL_SEND = 2'd2,
    SEL_RECV = 2'd3
  } sel_e;

  // control register bit positions
  localparam int CB_SEMPTY = 0;
  localparam int CB_SFULL  = 1;
  localparam int CB_IE_LO  = 2;
  localparam int CB_FLUSH  = 3;
  localparam int CB_REMPTY = 8;
  localparam int CB_RFULL  = 9;
  localparam int CB_IE_HI  = 10;
  localparam int CB_ERR    = 14;
  localparam int CB_EN     = 15;

  // sync register fields
  localparam int SY_IN_LSB  = 0;
  localparam int SY_OUT_LSB = 8;
  localparam int SY_AUX_LSB = 13;
endpackage

// File: rtl/ipc_fifo.sv
module ipc_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_req,
  input  logic [DW-1:0] wdata,
  input  logic          rd_req,
  input  logic          rd_pop,
  input  logic          flush,
  output logic [DW-1:0] rd_word,
  output logic          empty,
  output logic          full,
  output logic          wr_drop,
  output logic          rd_err
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] rp, wp;
  logic [CW-1:0] cnt;
  logic [DW-1:0] last_q;
  logic          do_pop, do_push;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign empty   = (cnt == '0);
  assign full    = (cnt == CW'(DEPTH));
  assign do_pop  = rd_req & rd_pop & ~empty & ~flush;
  assign do_push = wr_req & ~flush & (~full | do_pop);
  assign wr_drop = wr_req & ~flush & full & ~do_pop;
  assign rd_err  = rd_req & empty;
  assign rd_word = empty ? last_q : mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rp     <= '0;
      wp     <= '0;
      cnt    <= '0;
      last_q <= '0;
    end else begin
      if (rd_req && !empty) last_q <= mem[rp];
      if (flush) begin
        rp  <= '0;
        wp  <= '0;
        cnt <= '0;
      end else begin
        if (do_push) wp <= nxt(wp);
        if (do_pop)  rp <= nxt(rp);
        cnt <= cnt + CW'(do_push) - CW'(do_pop);
      end
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) cnt <= CW'(DEPTH)); // R5
  AST_FULL_DROP_KEEPS: assert property (@(posedge clk) disable iff (!rst_n) wr_drop |=> $stable(cnt)); // R9
  AST_PEEK_KEEPS: assert property (@(posedge clk) disable iff (!rst_n) (rd_req && !rd_pop && !wr_req && !flush) |=> $stable(cnt)); // R6
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n) flush |=> empty); // R10
  AST_BOTH_KEEP_COUNT: assert property (@(posedge clk) disable iff (!rst_n) (do_push && do_pop) |=> $stable(cnt)); // R11
endmodule

// File: rtl/ipc_side.sv
module ipc_side
  import ipc_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rd,
  input  logic                wr,
  input  logic [1:0]          sel,
  input  logic [1:0]          be,
  input  logic [15:0]         wdata,
  input  logic [NIB_W-1:0]    peer_nib,
  input  logic                own_empty,
  input  logic                own_full,
  input  logic                peer_empty,
  input  logic                peer_full,
  input  logic [DW-1:0]       rx_word,
  input  logic                err_evt,
  output logic [DW-1:0]       rdata,
  output logic                en,
  output logic                flush,
  output logic                push_req,
  output logic                pull_req,
  output logic [NIB_W-1:0]    out_nib
);
  logic [15:0]      wmask;
  logic [NIB_W-1:0] out_q;
  logic [1:0]       aux_q;
  logic             en_q, err_q, ie_lo_q, ie_hi_q;
  logic             sync_wr, ctrl_wr, err_clr;
  logic [15:0]      sync_rd, ctrl_rd;

  for (genvar k = 0; k < 2; k++) begin : g_lane
    assign wmask[8*k +: 8] = {8{be[k]}};
  end

  assign sync_wr  = wr && (sel == SEL_SYNC);
  assign ctrl_wr  = wr && (sel == SEL_CTRL);
  assign err_clr  = ctrl_wr & wmask[CB_ERR] & wdata[CB_ERR];
  assign flush    = ctrl_wr & wmask[CB_FLUSH] & wdata[CB_FLUSH];
  assign push_req = wr && (sel == SEL_SEND) && en_q;
  assign pull_req = rd && (sel == SEL_RECV);
  assign en       = en_q;
  assign out_nib  = out_q;

  function automatic logic upd(input logic old, input logic [15:0] m,
                               input logic [15:0] d, input int idx);
    return m[idx] ? d[idx] : old;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q   <= '0;
      aux_q   <= '0;
      en_q    <= 1'b0;
      err_q   <= 1'b0;
      ie_lo_q <= 1'b0;
      ie_hi_q <= 1'b0;
    end else begin
      if (sync_wr) begin
        for (int i = 0; i < NIB_W; i++)
          out_q[i] <= upd(out_q[i], wmask, wdata, SY_OUT_LSB + i);
        for (int i = 0; i < 2; i++)
          aux_q[i] <= upd(aux_q[i], wmask, wdata, SY_AUX_LSB + i);
      end
      if (ctrl_wr) begin
        en_q    <= upd(en_q, wmask, wdata, CB_EN);
        ie_lo_q <= upd(ie_lo_q, wmask, wdata, CB_IE_LO);
        ie_hi_q <= upd(ie_hi_q, wmask, wdata, CB_IE_HI);
      end
      if (err_evt)      err_q <= 1'b1;
      else if (err_clr) err_q <= 1'b0;
    end
  end

  always_comb begin
    sync_rd = '0;
    sync_rd[SY_IN_LSB  +: NIB_W] = peer_nib;
    sync_rd[SY_OUT_LSB +: NIB_W] = out_q;
    sync_rd[SY_AUX_LSB +: 2]     = aux_q;
    ctrl_rd = '0;
    ctrl_rd[CB_SEMPTY] = own_empty;
    ctrl_rd[CB_SFULL]  = own_full;
    ctrl_rd[CB_IE_LO]  = ie_lo_q;
    ctrl_rd[CB_REMPTY] = peer_empty;
    ctrl_rd[CB_RFULL]  = peer_full;
    ctrl_rd[CB_IE_HI]  = ie_hi_q;
    ctrl_rd[CB_ERR]    = err_q;
    ctrl_rd[CB_EN]     = en_q;
    unique case (sel)
      SEL_SYNC: rdata = DW'(sync_rd);
      SEL_CTRL: rdata = DW'(ctrl_rd);
      SEL_RECV: rdata = rx_word;
      default:  rdata = '0;
    endcase
  end

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (err_q && !err_clr) |=> err_q); // R8
  AST_ERR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) (err_clr && !err_evt) |=> !err_q); // R8
  AST_ERR_ON_EVENT: assert property (@(posedge clk) disable iff (!rst_n) err_evt |=> err_q); // R7
endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox
  import ipc_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             a_rd,
  input  logic             a_wr,
  input  logic [1:0]       a_sel,
  input  logic [3:0]       a_be,
  input  logic [REG_W-1:0] a_wdata,
  output logic [REG_W-1:0] a_rdata,
  input  logic             b_rd,
  input  logic             b_wr,
  input  logic [1:0]       b_sel,
  input  logic [3:0]       b_be,
  input  logic [REG_W-1:0] b_wdata,
  output logic [REG_W-1:0] b_rdata
);
  localparam int NS = 2;

  logic             rd [NS];
  logic             wr [NS];
  logic [1:0]       sel [NS];
  logic [3:0]       be [NS];
  logic [REG_W-1:0] wdat [NS];
  logic [REG_W-1:0] rdat [NS];
  logic [REG_W-1:0] head [NS];
  logic [NIB_W-1:0] nib [NS];
  logic             en [NS], flush [NS], push_req [NS], pull_req [NS];
  logic             empty [NS], full [NS], wr_drop [NS], rd_err [NS];
  logic             unused_hi_be;

  assign rd[0] = a_rd;  assign wr[0] = a_wr;  assign sel[0] = a_sel;
  assign be[0] = a_be;  assign wdat[0] = a_wdata;
  assign rd[1] = b_rd;  assign wr[1] = b_wr;  assign sel[1] = b_sel;
  assign be[1] = b_be;  assign wdat[1] = b_wdata;
  assign a_rdata = rdat[0];
  assign b_rdata = rdat[1];
  assign unused_hi_be = ^{a_be[3:2], b_be[3:2]};

  for (genvar g = 0; g < NS; g++) begin : g_side
    localparam int P = NS - 1 - g;

    ipc_side #(.DW(REG_W)) u_side (
      .clk        (clk),
      .rst_n      (rst_n),
      .rd         (rd[g]),
      .wr         (wr[g]),
      .sel        (sel[g]),
      .be         (be[g][1:0]),
      .wdata      (wdat[g][15:0]),
      .peer_nib   (nib[P]),
      .own_empty  (empty[g]),
      .own_full   (full[g]),
      .peer_empty (empty[P]),
      .peer_full  (full[P]),
      .rx_word    (head[P]),
      .err_evt    (wr_drop[g] | rd_err[P]),
      .rdata      (rdat[g]),
      .en         (en[g]),
      .flush      (flush[g]),
      .push_req   (push_req[g]),
      .pull_req   (pull_req[g]),
      .out_nib    (nib[g])
    );

    ipc_fifo #(.DW(REG_W), .DEPTH(DEPTH)) u_fifo (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_req  (push_req[g]),
      .wdata   (wdat[g]),
      .rd_req  (pull_req[P]),
      .rd_pop  (en[P]),
      .flush   (flush[g]),
      .rd_word (head[g]),
      .empty   (empty[g]),
      .full    (full[g]),
      .wr_drop (wr_drop[g]),
      .rd_err  (rd_err[g])
    );
  end
endmodule

// File: tb/tb_ipc_mailbox.sv
`timescale 1ns/1ps
module tb_ipc_mailbox;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        a_rd = 0, a_wr = 0, b_rd = 0, b_wr = 0;
  logic [1:0]  a_sel = 0, b_sel = 0;
  logic [3:0]  a_be = 0, b_be = 0;
  logic [31:0] a_wdata = 0, b_wdata = 0;
  logic [31:0] a_rdata, b_rdata;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  ipc_mailbox dut (.*);

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic acc(input bit s, input logic rd, input logic wr, input logic [1:0] sel,
                     input logic [3:0] be, input logic [31:0] d, output logic [31:0] q);
    @(negedge clk);
    if (!s) begin a_rd = rd; a_wr = wr; a_sel = sel; a_be = be; a_wdata = d; end
    else    begin b_rd = rd; b_wr = wr; b_sel = sel; b_be = be; b_wdata = d; end
    #1 q = s ? b_rdata : a_rdata;
    @(posedge clk); #1;
    a_rd = 0; a_wr = 0; b_rd = 0; b_wr = 0;
  endtask

  task automatic wreg(input bit s, input logic [1:0] sel, input logic [3:0] be, input logic [31:0] d);
    logic [31:0] q;
    acc(s, 1'b0, 1'b1, sel, be, d, q);
  endtask

  task automatic rreg(input bit s, input logic [1:0] sel, output logic [31:0] q);
    acc(s, 1'b1, 1'b0, sel, 4'h0, 32'h0, q);
  endtask

  task automatic chk_reg(input string req, input bit s, input logic [1:0] sel, input logic [31:0] exp);
    logic [31:0] q;
    rreg(s, sel, q);
    check(req, q, exp);
  endtask

  task automatic dual_push_pop(input logic [31:0] d, output logic [31:0] q);
    @(negedge clk);
    a_wr = 1; a_sel = 2; a_be = 4'hF; a_wdata = d;
    b_rd = 1; b_sel = 3;
    #1 q = b_rdata;
    @(posedge clk); #1;
    a_wr = 0; b_rd = 0;
  endtask

  task automatic t_reset();
    chk_reg("R1 sync A", 0, 0, 32'h0);
    chk_reg("R1 sync B", 1, 0, 32'h0);
    chk_reg("R1 ctrl A", 0, 1, 32'h0101);
    chk_reg("R1 ctrl B", 1, 1, 32'h0101);
  endtask

  task automatic t_sync();
    wreg(0, 0, 4'hF, 32'hFFFF_FFFF);
    chk_reg("R2 sync A mask", 0, 0, 32'h6F00);
    chk_reg("R2 sync B mirror", 1, 0, 32'h000F);
    wreg(1, 0, 4'h3, 32'h0000_0500);
    chk_reg("R2 sync A peer nibble", 0, 0, 32'h6F05);
    wreg(0, 0, 4'h1, 32'h0);
    chk_reg("R12 sync lane1 kept", 0, 0, 32'h6F05);
    wreg(0, 0, 4'h2, 32'h0);
    chk_reg("R12 sync lane1 written", 0, 0, 32'h0005);
    chk_reg("R2 sync B after clear", 1, 0, 32'h0500);
  endtask

  task automatic t_ctrl();
    wreg(0, 1, 4'h3, 32'h0000_FFFF);
    chk_reg("R3 ctrl A mask", 0, 1, 32'h8505);
    wreg(0, 1, 4'h2, 32'h0);
    chk_reg("R12 ctrl lane0 kept", 0, 1, 32'h0105);
    wreg(0, 1, 4'h3, 32'h0);
    chk_reg("R3 ctrl A cleared", 0, 1, 32'h0101);
  endtask

  task automatic t_disabled_and_err();
    logic [31:0] q;
    wreg(0, 2, 4'hF, 32'h11);
    chk_reg("R4 ctrl A unchanged", 0, 1, 32'h0101);
    chk_reg("R4 ctrl B unchanged", 1, 1, 32'h0101);
    rreg(1, 3, q);
    check("R7 empty read never read", q, 32'h0);
    chk_reg("R7 B error set", 1, 1, 32'h4101);
    wreg(1, 1, 4'h3, 32'h0);
    chk_reg("R8 write 0 keeps err", 1, 1, 32'h4101);
    wreg(1, 1, 4'h3, 32'h4000);
    chk_reg("R8 write 1 clears err", 1, 1, 32'h0101);
  endtask

  task automatic t_fill_drain();
    logic [31:0] q;
    wreg(0, 1, 4'h3, 32'h8000);
    wreg(1, 1, 4'h3, 32'h8000);
    wreg(0, 2, 4'hF, 32'hA000_0000);
    chk_reg("R5 A one word", 0, 1, 32'h8100);
    chk_reg("R5 B sees nonempty", 1, 1, 32'h8001);
    for (int i = 1; i < 16; i++) wreg(0, 2, 4'hF, 32'hA000_0000 + i);
    chk_reg("R5 A full", 0, 1, 32'h8102);
    chk_reg("R5 B recv full", 1, 1, 32'h8201);
    wreg(0, 2, 4'hF, 32'hDEAD);
    chk_reg("R9 A err on full push", 0, 1, 32'hC102);
    for (int i = 0; i < 16; i++) begin
      rreg(1, 3, q);
      check($sformatf("R5 order word %0d", i), q, 32'hA000_0000 + i);
    end
    chk_reg("R9 drained, no extra word", 1, 1, 32'h8101);
    chk_reg("R5 A empty err kept", 0, 1, 32'hC101);
    wreg(0, 1, 4'h3, 32'hC000);
    chk_reg("R8 A err cleared", 0, 1, 32'h8101);
  endtask

  task automatic t_peek();
    logic [31:0] q;
    wreg(0, 2, 4'hF, 32'h55);
    wreg(0, 2, 4'hF, 32'h66);
    wreg(1, 1, 4'h3, 32'h0);
    rreg(1, 3, q); check("R6 peek first", q, 32'h55);
    rreg(1, 3, q); check("R6 peek again", q, 32'h55);
    chk_reg("R6 still nonempty", 1, 1, 32'h0001);
    wreg(1, 1, 4'h3, 32'h8000);
    rreg(1, 3, q); check("R6 pop head", q, 32'h55);
    rreg(1, 3, q); check("R6 pop second", q, 32'h66);
    rreg(1, 3, q); check("R7 empty repeats last", q, 32'h66);
    chk_reg("R7 B err", 1, 1, 32'hC101);
    wreg(1, 1, 4'h3, 32'hC000);
  endtask

  task automatic t_simul_and_flush();
    logic [31:0] q;
    wreg(0, 2, 4'hF, 32'h77);
    dual_push_pop(32'h88, q);
    check("R11 pop returns head", q, 32'h77);
    chk_reg("R11 one word left", 0, 1, 32'h8100);
    rreg(1, 3, q); check("R11 pushed word kept", q, 32'h88);
    for (int i = 0; i < 16; i++) wreg(0, 2, 4'hF, 32'h100 + i);
    dual_push_pop(32'hBEEF, q);
    check("R11 full pop returns head", q, 32'h100);
    chk_reg("R11 full no error", 0, 1, 32'h8102);
    wreg(0, 1, 4'h1, 32'h0000_0008);
    chk_reg("R10 A send empty", 0, 1, 32'h8101);
    chk_reg("R10 B recv empty", 1, 1, 32'h8101);
    rreg(1, 3, q); check("R10 flushed read gives last", q, 32'h100);
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog got timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_sync();
    t_ctrl();
    t_disabled_and_err();
    t_fill_drain();
    t_peek();
    t_simul_and_flush();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule